// File: doc/BRIEF.md
# Printer Port Control and Status Registers

This block is the host-facing register pair of a PC-style printer port. A read-only status register reports the levels of five peripheral input lines. A read/write control register drives four peripheral output lines and holds an interrupt enable and a data-direction request. The host reaches both registers over a byte-wide register bus with an address offset, read and write strobes, and a chip select. The whole block runs on one clock with an active-low reset.

All five peripheral inputs pass through a two-flop synchronizer before the host sees them. The synchronized acknowledge line also feeds a rising-edge detector. When the interrupt enable is set, a rising acknowledge raises a level interrupt request. The request stays up until the host reads the status register or clears the enable.

A 3-bit port mode input sets whether the direction request is honoured. The block reports the resulting effective direction on an output, so the data-path logic outside this block can use it.

Top module: `ppcs_regs`

## Requirements
- R1: A read of offset 1 returns the status byte. Bits 2..0 are 0. Bit 3 is the fault_n level, bit 4 is select, bit 5 is perror and bit 6 is ack_n, each taken after synchronization.
- R2: Status bit 7 reads the inverse of the busy input level.
- R3: A write to offset 2 stores wdata bits 5..0 in the control register, and a read of offset 2 returns them. Control bits 7..6 always read 0, whatever was written.
- R4: After reset the control register is 0. The outputs are then strobe_n_o=1, autofd_n_o=1, init_n_o=0, slctin_n_o=1, dir_in_o=0 and irq_o=0.
- R5: Control bit 0 drives strobe_n_o inverted, bit 1 drives autofd_n_o inverted and bit 3 drives slctin_n_o inverted. Bit 2 drives init_n_o without inversion.
- R6: When mode is 3'b000 or 3'b010, dir_in_o is 0 (output) whatever control bit 5 holds.
- R7: In every other mode, dir_in_o equals control bit 5 (1 = input).
- R8: A level change on a status input shows in the status read no more than three clock edges after it is applied.
- R9: While control bit 4 is 1, a rising edge on ack_n_i sets irq_o.
- R10: irq_o stays at 1 until a status read (offset 1) or until control bit 4 is cleared. Either event drops it.
- R11: A rising ack_n_i edge that arrives while control bit 4 is 0 is not remembered. Setting the enable later does not raise irq_o.
- R12: Reads of offsets other than 1 and 2, and any cycle without cs and rd both high, return 0. Writes to other offsets, or writes with cs low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select for the register bus |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register offset from the port base |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when no valid read is in progress |
| mode | input | 3 | Port mode |
| fault_n_i | input | 1 | Peripheral fault line, active low |
| select_i | input | 1 | Peripheral selected line |
| perror_i | input | 1 | Peripheral paper-error line |
| ack_n_i | input | 1 | Peripheral acknowledge line, active low |
| busy_i | input | 1 | Peripheral busy line |
| strobe_n_o | output | 1 | Strobe to the peripheral, active low |
| autofd_n_o | output | 1 | Auto line-feed request, active low |
| init_n_o | output | 1 | Peripheral initialise, active low |
| slctin_n_o | output | 1 | Select-in to the peripheral, active low |
| dir_in_o | output | 1 | Effective data direction, 1 = input |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The assertions check the following on every cycle:
- status bits 2..0 and control bits 7..6 read as zero;
- a control write reaches the pins one cycle later with the right inversion;
- the forced-output modes give output direction;
- an enabled acknowledge edge sets the request;
- a status read or a cleared enable drops the request.

Some behaviours need sequences built on purpose, so only the bench's scenarios show them:
- the synchronizer latency on status reads;
- the free direction modes;
- an edge that arrives while the enable is off and is then forgotten;
- writes ignored at unused offsets or with the chip deselected, seen through later readback.

// File: rtl/ppcs_pkg.sv
package ppcs_pkg;

  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int CTRL_W = 6;
  localparam int STAT_LINES = 5;

  typedef struct packed {
    logic dir_req;
    logic irq_en;
    logic slct_in;
    logic init_lvl;
    logic autofd;
    logic strobe;
  } ctrl_t;

  typedef struct packed {
    logic busy;
    logic ack_n;
    logic perror;
    logic select;
    logic fault_n;
  } stat_t;

  function automatic logic [BYTE_W-1:0] pack_status(input stat_t s);
    pack_status = {~s.busy, s.ack_n, s.perror, s.select, s.fault_n, 3'b000};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
    pack_ctrl = {{(BYTE_W-CTRL_W){1'b0}}, c};
  endfunction

  function automatic logic mode_forces_out(input logic [MODE_W-1:0] m);
    mode_forces_out = (m == 3'b000) || (m == 3'b010);
  endfunction

  function automatic logic eff_dir_in(input logic [MODE_W-1:0] m, input logic req);
    eff_dir_in = req & ~mode_forces_out(m);
  endfunction

endpackage

// File: rtl/ppcs_sync.sv
module ppcs_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ppcs_ctrl.sv
module ppcs_ctrl
  import ppcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [MODE_W-1:0] mode,
  output ctrl_t             ctrl_q,
  output logic              strobe_n_o,
  output logic              autofd_n_o,
  output logic              init_n_o,
  output logic              slctin_n_o,
  output logic              dir_in_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign strobe_n_o = ~ctrl_q.strobe;
  assign autofd_n_o = ~ctrl_q.autofd;
  assign slctin_n_o = ~ctrl_q.slct_in;
  assign init_n_o   = ctrl_q.init_lvl;
  assign dir_in_o   = eff_dir_in(mode, ctrl_q.dir_req);

endmodule

// File: rtl/ppcs_irq.sv
module ppcs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_sync,
  input  logic irq_en,
  input  logic stat_rd,
  output logic ack_rise,
  output logic irq_o
);

  logic ack_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b0;
    else        ack_prev <= ack_sync;
  end

  assign ack_rise = ack_sync & ~ack_prev;

  // A new edge wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_en & (ack_rise | (irq_o & ~stat_rd));
  end

endmodule

// File: rtl/ppcs_regs.sv
module ppcs_regs
  import ppcs_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STAT_OFS    = 1,
  parameter int CTRL_OFS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [2:0]        mode,
  input  logic              fault_n_i,
  input  logic              select_i,
  input  logic              perror_i,
  input  logic              ack_n_i,
  input  logic              busy_i,
  output logic              strobe_n_o,
  output logic              autofd_n_o,
  output logic              init_n_o,
  output logic              slctin_n_o,
  output logic              dir_in_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  stat_t stat_raw, stat_s;
  ctrl_t ctrl_q;
  logic  hit_stat, hit_ctrl, stat_rd, wr_ctrl;
  logic  ack_rise, irq_en;

  assign hit_stat = cs & (addr == STAT_A);
  assign hit_ctrl = cs & (addr == CTRL_A);
  assign stat_rd  = hit_stat & rd;
  assign wr_ctrl  = hit_ctrl & wr;

  assign stat_raw = '{busy: busy_i, ack_n: ack_n_i, perror: perror_i,
                      select: select_i, fault_n: fault_n_i};

  ppcs_sync #(.WIDTH(STAT_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(stat_raw), .q_o(stat_s)
  );

  ppcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata), .mode(mode),
    .ctrl_q(ctrl_q), .strobe_n_o(strobe_n_o), .autofd_n_o(autofd_n_o),
    .init_n_o(init_n_o), .slctin_n_o(slctin_n_o), .dir_in_o(dir_in_o)
  );

  assign irq_en = ctrl_q.irq_en;

  ppcs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_sync(stat_s.ack_n), .irq_en(irq_en),
    .stat_rd(stat_rd), .ack_rise(ack_rise), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (addr == STAT_A)      rdata = pack_status(stat_s);
      else if (addr == CTRL_A) rdata = pack_ctrl(ctrl_q);
    end
  end

endmodule

// File: rtl/ppcs_regs_chk.sv
module ppcs_regs_chk #(
  parameter int ADDR_W   = 3,
  parameter int STAT_OFS = 1,
  parameter int CTRL_OFS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [2:0]        mode,
  input logic              strobe_n_o,
  input logic              autofd_n_o,
  input logic              init_n_o,
  input logic              slctin_n_o,
  input logic              dir_in_o,
  input logic              irq_o,
  input logic              ack_rise,
  input logic              irq_en
);

  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFS);

  a_r1_stat_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == SA) |-> (rdata[2:0] == 3'b000));

  a_r3_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == CA) |-> (rdata[7:6] == 2'b00));

  a_r5_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == CA) |=>
      (strobe_n_o == !$past(wdata[0]) && autofd_n_o == !$past(wdata[1]) &&
       init_n_o == $past(wdata[2]) && slctin_n_o == !$past(wdata[3])));

  a_r6_forced_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 || mode == 3'b010) |-> !dir_in_o);

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && irq_en) |=> irq_o);

  a_r10_irq_drop_en: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_o);

  a_r10_irq_drop_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == SA && !ack_rise) |=> !irq_o);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> (rdata == 8'h00));

endmodule

bind ppcs_regs ppcs_regs_chk #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mode(mode), .strobe_n_o(strobe_n_o),
  .autofd_n_o(autofd_n_o), .init_n_o(init_n_o), .slctin_n_o(slctin_n_o),
  .dir_in_o(dir_in_o), .irq_o(irq_o), .ack_rise(ack_rise), .irq_en(irq_en)
);

// File: tb/ppcs_regs_tb.sv
`timescale 1ns/1ps
module ppcs_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] mode = '0;
  logic       fault_n_i = 0, select_i = 0, perror_i = 0, ack_n_i = 0, busy_i = 0;
  logic       strobe_n_o, autofd_n_o, init_n_o, slctin_n_o, dir_in_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ppcs_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mode(mode), .fault_n_i(fault_n_i),
    .select_i(select_i), .perror_i(perror_i), .ack_n_i(ack_n_i),
    .busy_i(busy_i), .strobe_n_o(strobe_n_o), .autofd_n_o(autofd_n_o),
    .init_n_o(init_n_o), .slctin_n_o(slctin_n_o), .dir_in_o(dir_in_o),
    .irq_o(irq_o)
  );

  function automatic logic [7:0] want_status(logic f, logic s, logic p, logic a, logic b);
    logic [7:0] v = 8'h00;
    v[3] = f; v[4] = s; v[5] = p; v[6] = a; v[7] = !b;
    return v;
  endfunction

  function automatic logic want_dir(logic [2:0] m, logic req);
    if (m == 3'd0 || m == 3'd2) return 1'b0;
    return req;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d, logic sel);
    @(negedge clk);
    cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic check_pins(string req, logic [5:0] c);
    check(req, {4'h0, strobe_n_o, autofd_n_o, init_n_o, slctin_n_o},
          {4'h0, !c[0], !c[1], c[2], !c[3]});
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [5:0] shadow;
    void'($urandom(32'h5eed_1234));

    tick(3);
    // R4: reset state
    check("R4", {2'b0, strobe_n_o, autofd_n_o, init_n_o, slctin_n_o, dir_in_o, irq_o},
          8'b00_1101_00);
    rst_n = 1;
    tick(2);
    bus_read(3'd2, d); check("R4", d, 8'h00);
    shadow = '0;

    // R12: no read strobe gives zero
    check("R12", rdata, 8'h00);

    // Random control writes with random modes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      w[4] = 1'b0;
      mode = 3'($urandom);
      bus_write(3'd2, w, 1'b1);
      shadow = w[5:0];
      check_pins("R5", shadow);
      check(want_dir(mode, shadow[5]) ? "R7" : "R6", {7'h0, dir_in_o},
            {7'h0, want_dir(mode, shadow[5])});
      bus_read(3'd2, d);
      check("R3", d, {2'b00, shadow});
    end

    // R6 directed: direction requested as input but forced out
    bus_write(3'd2, 8'h20, 1'b1); shadow = 6'h20;
    mode = 3'b000; #1 check("R6", {7'h0, dir_in_o}, 8'h00);
    mode = 3'b010; #1 check("R6", {7'h0, dir_in_o}, 8'h00);
    mode = 3'b001; #1 check("R7", {7'h0, dir_in_o}, 8'h01);
    mode = 3'b111; #1 check("R7", {7'h0, dir_in_o}, 8'h01);

    // R12: writes to other offsets or deselected do nothing
    bus_write(3'd2, 8'h0F, 1'b0);
    bus_write(3'd3, 8'h0F, 1'b1);
    bus_write(3'd1, 8'h0F, 1'b1);
    bus_read(3'd2, d); check("R12", d, 8'h20);
    check_pins("R12", shadow);
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) begin
        bus_read(3'(a), d); check("R12", d, 8'h00);
      end
    end

    // Random status patterns (R1, R2, R8)
    for (int i = 0; i < 40; i++) begin
      logic [4:0] v;
      v = 5'($urandom);
      @(negedge clk);
      {fault_n_i, select_i, perror_i, ack_n_i, busy_i} = v;
      tick(2);
      bus_read(3'd1, d);
      check((i % 2) ? "R2" : "R1", d, want_status(v[4], v[3], v[2], v[1], v[0]));
    end

    // R8: visible within three edges of a change
    @(negedge clk); busy_i = 0; fault_n_i = 1;
    tick(3);
    bus_read(3'd1, d); check("R8", d[7:3], want_status(1'b1, select_i, perror_i, ack_n_i, 1'b0) >> 3);
    @(negedge clk); busy_i = 1; fault_n_i = 0;
    @(negedge clk); @(negedge clk);
    cs = 1; rd = 1; addr = 3'd1; #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
    check("R8", {d[7], d[3]}, 2'b00);

    // R9/R10: enabled edge raises and holds, status read drops
    @(negedge clk); ack_n_i = 0;
    bus_write(3'd2, 8'h10, 1'b1);
    tick(4);
    check("R9", {7'h0, irq_o}, 8'h00);
    @(negedge clk); ack_n_i = 1;
    tick(4);
    check("R9", {7'h0, irq_o}, 8'h01);
    bus_read(3'd3, d);
    tick(3);
    check("R10", {7'h0, irq_o}, 8'h01);
    bus_read(3'd1, d);
    check("R10", {7'h0, irq_o}, 8'h00);

    // R10: clearing the enable drops the request
    @(negedge clk); ack_n_i = 0; tick(4);
    @(negedge clk); ack_n_i = 1; tick(4);
    check("R9", {7'h0, irq_o}, 8'h01);
    bus_write(3'd2, 8'h00, 1'b1);
    tick(1);
    check("R10", {7'h0, irq_o}, 8'h00);

    // R11: edge while disabled is forgotten
    @(negedge clk); ack_n_i = 0; tick(4);
    @(negedge clk); ack_n_i = 1; tick(4);
    check("R11", {7'h0, irq_o}, 8'h00);
    bus_write(3'd2, 8'h10, 1'b1);
    tick(5);
    check("R11", {7'h0, irq_o}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule